// File: doc/BRIEF.md
# Pointer Address Generator for Signal-Processing Loops

This block holds one data pointer and computes the effective address of the current memory access. The pointer is advanced by dedicated logic, so the arithmetic datapath is never used for this. A signed step is added on each update strobe. Three addressing modes are supported: plain wrap-around arithmetic, a circular window given by a base and a length, and reversed-carry stepping for reordering radix-2 FFT data.

Software loads the pointer, step, base and length through one write port, and selects the mode, the FFT order and whether modification happens before or after the access. Each cycle with the strobe high is one access. The address output is combinational from the registered pointer and the current controls, so the access and the pointer advance happen in the same cycle. The block is a plain control and status interface. It does not stream data, so there is no valid/ready pair and no back-pressure.

When the configuration is illegal, an error output is raised and the strobe is ignored. This keeps the pointer from leaving its window.

Top module: `addr_gen_unit`

## Requirements
- R1: After reset the pointer, step, base and length registers are all zero. With mode 0 selected, the address is 0 and the error output is 0.
- R2: A configuration write is selected by `cfg_sel` (0 = pointer, 1 = step, 2 = base, 3 = length) and takes effect at the next clock edge. A pointer write in the same cycle as an update strobe wins over the update. Any update in that cycle uses the register values from before the write.
- R3: With `pre_mod` low and an accepted update, the address is the current pointer, and the pointer becomes the next value at the clock edge.
- R4: With `pre_mod` high and an accepted update, the address is the next pointer value in the same cycle, and the pointer takes that same value at the edge.
- R5: In mode 0, the next value is the pointer plus the sign-extended step, modulo 2^AW.
- R6: In mode 1, when pointer plus a non-negative step reaches or passes base+length, the next value is that sum minus the length.
- R7: In mode 1, when pointer plus a negative step falls below the base, the next value is that sum plus the length.
- R8: In mode 2 with order k (`fft_lg`), the low k bits step through a bit-reversed count. Starting from 0 with step 1 and k = 3, the low bits run 0, 4, 2, 6, 1, 5, 3, 7.
- R9: In mode 2, the pointer bits at position k and above are unchanged, and a negative step walks the reversed count backwards.
- R10: The error output is high in mode 1 when |step| ≥ length, in mode 2 when `fft_lg` is 0 or greater than MAX_LG, and always in mode 3. While it is high, an update strobe leaves the pointer unchanged and the address equals the pointer.
- R11: Without an update strobe or a pointer write, the pointer holds and the address equals it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Register select: 0 pointer, 1 step, 2 base, 3 length |
| cfg_wdata | input | AW | Write data; the step is two's complement |
| mode | input | 2 | 0 linear, 1 circular, 2 bit-reversed, 3 reserved |
| pre_mod | input | 1 | 1 = modify before the access, 0 = after |
| fft_lg | input | LW | log2 of the FFT size for mode 2 |
| upd | input | 1 | Update strobe, one access per cycle |
| addr | output | AW | Effective address of the current access |
| err | output | 1 | Illegal configuration for the selected mode |

## Verification
The circular-window assertion assumes that the pointer sits inside [base, base+length) before an update. It also assumes that no register write happens in the same cycle. Only under those conditions does the wrap rule keep the pointer in the window. The stimulus therefore reloads the pointer to a value inside the window whenever it changes the base or the length. The bit-reversed property assumes that the base is aligned to the FFT size, so the bench sets the low order bits of the pointer itself. The random phase draws steps mostly below the length but occasionally equal to or beyond it, so that the error path and its ignored strobe are covered too.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AM_LINEAR = 2'd0,
    AM_CIRC   = 2'd1,
    AM_BITREV = 2'd2,
    AM_RSVD   = 2'd3
  } agu_mode_e;

  typedef enum logic [1:0] {
    RS_PTR  = 2'd0,
    RS_STEP = 2'd1,
    RS_BASE = 2'd2,
    RS_LEN  = 2'd3
  } agu_reg_e;
endpackage

// File: rtl/agu_regs.sv
module agu_regs #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          adv,
  input  logic [AW-1:0] adv_ptr,
  output logic [AW-1:0] ptr_q,
  output logic [AW-1:0] step_q,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] len_q
);
  import agu_pkg::*;

  // pointer: a software write has priority over the hardware advance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (wr_en && agu_reg_e'(wr_sel) == RS_PTR) begin
      ptr_q <= wr_data;
    end else if (adv) begin
      ptr_q <= adv_ptr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      base_q <= '0;
      len_q  <= '0;
    end else if (wr_en) begin
      case (agu_reg_e'(wr_sel))
        RS_STEP: step_q <= wr_data;
        RS_BASE: base_q <= wr_data;
        RS_LEN:  len_q  <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/agu_circ.sv
module agu_circ #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] nxt,
  output logic          bad
);
  localparam int EW = AW + 2;

  logic signed [EW-1:0] p_x, s_x, b_x, l_x, lim_x, sum_x, mag_x, res_x;

  always_comb begin
    p_x   = signed'({2'b00, ptr});
    b_x   = signed'({2'b00, base});
    l_x   = signed'({2'b00, len});
    s_x   = signed'({{2{step[AW-1]}}, step});
    lim_x = b_x + l_x;
    sum_x = p_x + s_x;
    mag_x = s_x[EW-1] ? -s_x : s_x;
    bad   = (mag_x >= l_x);
    if (!s_x[EW-1] && sum_x >= lim_x) begin
      res_x = sum_x - l_x;
    end else if (s_x[EW-1] && sum_x < b_x) begin
      res_x = sum_x + l_x;
    end else begin
      res_x = sum_x;
    end
    nxt = res_x[AW-1:0];
  end
endmodule

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
  parameter int AW = 16,
  parameter int ML = 10,
  parameter int LW = 4
) (
  input  logic [AW-1:0] ptr,
  input  logic [ML-1:0] step_lo,
  input  logic [LW-1:0] lg,
  output logic [AW-1:0] nxt,
  output logic          bad
);
  localparam int HW = AW - ML;

  logic [LW-1:0] kk, shamt;
  logic [ML-1:0] msk, low_in, rev_a, ctr, sum, rev_b, new_low;

  always_comb begin
    bad    = (lg == '0) || (lg > LW'(ML));
    kk     = bad ? LW'(1) : lg;
    shamt  = LW'(ML) - kk;
    msk    = (ML'(1) << kk) - ML'(1);
    low_in = ptr[ML-1:0] & msk;
  end

  // full-width mirror; the shift then aligns the k-bit reversed field
  for (genvar i = 0; i < ML; i++) begin : g_mirror
    assign rev_a[i] = low_in[ML-1-i];
    assign rev_b[i] = sum[ML-1-i];
  end

  always_comb begin
    ctr     = rev_a >> shamt;
    sum     = (ctr + step_lo) & msk;
    new_low = rev_b >> shamt;
    nxt     = (ptr & ~{{HW{1'b0}}, msk}) | {{HW{1'b0}}, new_low};
  end
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit #(
  parameter int AW     = 16,
  parameter int MAX_LG = 10,
  parameter int LW     = $clog2(MAX_LG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic [1:0]    mode,
  input  logic          pre_mod,
  input  logic [LW-1:0] fft_lg,
  input  logic          upd,
  output logic [AW-1:0] addr,
  output logic          err
);
  import agu_pkg::*;

  logic [AW-1:0] ptr_q, step_q, base_q, len_q;
  logic [AW-1:0] lin_nxt, circ_nxt, rev_nxt, sel_nxt;
  logic          circ_bad, rev_bad, take;

  agu_regs #(.AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .adv     (take),
    .adv_ptr (sel_nxt),
    .ptr_q   (ptr_q),
    .step_q  (step_q),
    .base_q  (base_q),
    .len_q   (len_q)
  );

  agu_circ #(.AW(AW)) u_circ (
    .ptr  (ptr_q),
    .step (step_q),
    .base (base_q),
    .len  (len_q),
    .nxt  (circ_nxt),
    .bad  (circ_bad)
  );

  agu_bitrev #(.AW(AW), .ML(MAX_LG), .LW(LW)) u_rev (
    .ptr     (ptr_q),
    .step_lo (step_q[MAX_LG-1:0]),
    .lg      (fft_lg),
    .nxt     (rev_nxt),
    .bad     (rev_bad)
  );

  assign lin_nxt = ptr_q + step_q;

  always_comb begin
    case (agu_mode_e'(mode))
      AM_LINEAR: begin sel_nxt = lin_nxt;  err = 1'b0;     end
      AM_CIRC:   begin sel_nxt = circ_nxt; err = circ_bad; end
      AM_BITREV: begin sel_nxt = rev_nxt;  err = rev_bad;  end
      default:   begin sel_nxt = ptr_q;    err = 1'b1;     end
    endcase
    take = upd && !err;
    addr = (take && pre_mod) ? sel_nxt : ptr_q;
  end
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int AW = 16,
  parameter int ML = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic [AW-1:0] cfg_wdata,
  input logic [1:0]    mode,
  input logic          pre_mod,
  input logic          upd,
  input logic          err,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] ptr_q,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] len_q
);
  logic ptr_wr, in_win;
  assign ptr_wr = cfg_we && (cfg_sel == 2'd0);
  assign in_win = ({1'b0, ptr_q} >= {1'b0, base_q}) &&
                  ({1'b0, ptr_q} < ({1'b0, base_q} + {1'b0, len_q}));

  p_ptr_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> ptr_q == $past(cfg_wdata));

  p_post_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !pre_mod |-> addr == ptr_q);

  p_pre_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd && pre_mod && !err && !ptr_wr |=> ptr_q == $past(addr));

  p_stay_in_win_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd1 && upd && !err && !cfg_we && in_win |=> in_win);

  p_high_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd2 && upd && !err && !cfg_we |=> ptr_q[AW-1:ML] == $past(ptr_q[AW-1:ML]));

  p_err_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> mode != 2'd0);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd || err) && !ptr_wr |=> ptr_q == $past(ptr_q));
endmodule

bind addr_gen_unit agu_chk #(.AW(AW), .ML(MAX_LG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .cfg_wdata (cfg_wdata),
  .mode      (mode),
  .pre_mod   (pre_mod),
  .upd       (upd),
  .err       (err),
  .addr      (addr),
  .ptr_q     (ptr_q),
  .base_q    (base_q),
  .len_q     (len_q)
);

// File: tb/sim_addr_gen_unit.sv
`timescale 1ns/1ps
module sim_addr_gen_unit;
  localparam int AW = 16;
  localparam int ML = 10;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [1:0] mode = '0;
  logic pre_mod = 1'b0;
  logic [LW-1:0] fft_lg = '0;
  logic upd = 1'b0;
  logic [AW-1:0] addr;
  logic err;

  always #5 clk = ~clk;

  addr_gen_unit #(.AW(AW), .MAX_LG(ML), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mode(mode), .pre_mod(pre_mod), .fft_lg(fft_lg),
    .upd(upd), .addr(addr), .err(err)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference state
  int m_ptr = 0, m_step = 0, m_base = 0, m_len = 0;

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sx(int v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  function automatic int rev_bits(int v, int k);
    int r = 0;
    for (int i = 0; i < k; i++) if ((v >> i) & 1) r |= 1 << (k - 1 - i);
    return r;
  endfunction

  function automatic bit m_err(int md, int lg);
    int s = sx(m_step);
    int a = (s < 0) ? -s : s;
    if (md == 3) return 1;
    if (md == 1) return a >= m_len;
    if (md == 2) return (lg < 1) || (lg > ML);
    return 0;
  endfunction

  function automatic int m_next(int md, int lg);
    int s = sx(m_step);
    int n, msk, low;
    case (md)
      0: n = m_ptr + s;
      1: begin
        n = m_ptr + s;
        if (s >= 0 && n >= m_base + m_len) n = n - m_len;
        else if (s < 0 && n < m_base) n = n + m_len;
      end
      2: begin
        msk = (1 << lg) - 1;
        low = (rev_bits(m_ptr & msk, lg) + s) & msk;
        n = (m_ptr & ~msk) | rev_bits(low, lg);
      end
      default: n = m_ptr;
    endcase
    return n & 16'hFFFF;
  endfunction

  int last_addr;

  // one clock: drive at negedge, compare just before posedge, advance model
  task automatic cyc(string req, bit we, int sel, int wd, int md, bit pre, int lg, bit up);
    bit e;
    int nx, ea;
    @(negedge clk);
    cfg_we = we; cfg_sel = 2'(sel); cfg_wdata = AW'(wd);
    mode = 2'(md); pre_mod = pre; fft_lg = LW'(lg); upd = up;
    #3;
    e  = m_err(md, lg);
    nx = m_next(md, lg);
    ea = (up && !e && pre) ? nx : m_ptr;
    chk({req, " addr"}, int'(addr), ea);
    chk({req, " err"}, int'(err), int'(e));
    last_addr = int'(addr);
    @(posedge clk);
    #1;
    if (we && sel == 0) m_ptr = wd & 16'hFFFF;
    else if (up && !e) m_ptr = nx;
    if (we && sel == 1) m_step = wd & 16'hFFFF;
    if (we && sel == 2) m_base = wd & 16'hFFFF;
    if (we && sel == 3) m_len = wd & 16'hFFFF;
  endtask

  task automatic wr(int sel, int wd);
    cyc("R2", 1, sel, wd, 0, 0, 3, 0);
  endtask

  initial begin : watchdog
    #2_000_000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  int exp_seq[8] = '{0, 4, 2, 6, 1, 5, 3, 7};

  initial begin : main
    // R1: reset state
    repeat (2) @(negedge clk);
    #3;
    chk("R1 addr", int'(addr), 0);
    chk("R1 err", int'(err), 0);
    @(negedge clk); rst_n = 1'b1;
    cyc("R1", 0, 0, 0, 0, 0, 0, 0);
    cyc("R1", 0, 0, 0, 0, 0, 0, 1);

    // R3/R5: linear, post-modify
    wr(0, 100); wr(1, 3);
    for (int i = 0; i < 4; i++) cyc("R3", 0, 0, 0, 0, 0, 0, 1);
    // R4: pre-modify
    for (int i = 0; i < 3; i++) cyc("R4", 0, 0, 0, 0, 1, 0, 1);
    // R5: wrap below zero
    wr(0, 2); wr(1, 16'hFFFB);
    cyc("R5", 0, 0, 0, 0, 0, 0, 1);
    cyc("R5", 0, 0, 0, 0, 0, 0, 1);
    chk("R5 wrap", last_addr, 65533);

    // R11: hold without strobe
    for (int i = 0; i < 3; i++) cyc("R11", 0, 0, 0, 0, 1, 0, 0);

    // R6: circular forward
    wr(2, 16'h0200); wr(3, 10); wr(1, 3); wr(0, 16'h0200);
    for (int i = 0; i < 8; i++) cyc("R6", 0, 0, 0, 1, 0, 0, 1);
    for (int i = 0; i < 4; i++) cyc("R6", 0, 0, 0, 1, 1, 0, 1);
    // R7: circular backward
    wr(1, 16'hFFFC); wr(0, 16'h0201);
    cyc("R7", 0, 0, 0, 1, 0, 0, 1);
    cyc("R7", 0, 0, 0, 1, 0, 0, 1);
    chk("R7 wrap", last_addr, 16'h0207);
    for (int i = 0; i < 6; i++) cyc("R7", 0, 0, 0, 1, 1, 0, 1);

    // R10: step magnitude equal to length, strobe ignored
    wr(1, 10);
    for (int i = 0; i < 3; i++) cyc("R10", 0, 0, 0, 1, 1, 0, 1);
    wr(1, 16'hFFF6);
    for (int i = 0; i < 2; i++) cyc("R10", 0, 0, 0, 1, 0, 0, 1);
    for (int i = 0; i < 2; i++) cyc("R10", 0, 0, 0, 3, 1, 3, 1);

    // R8: 8-point reversed sequence
    wr(0, 16'h1238); wr(1, 1);
    for (int i = 0; i < 8; i++) begin
      cyc("R8", 0, 0, 0, 2, 0, 3, 1);
      chk("R8 seq", last_addr, 16'h1238 + exp_seq[i]);
    end
    // R9: backward walk and larger orders
    wr(1, 16'hFFFF);
    for (int i = 0; i < 8; i++) cyc("R9", 0, 0, 0, 2, 1, 3, 1);
    wr(0, 16'hFC00); wr(1, 1);
    for (int i = 0; i < 6; i++) cyc("R9", 0, 0, 0, 2, 0, 10, 1);
    wr(1, 5);
    for (int i = 0; i < 6; i++) cyc("R9", 0, 0, 0, 2, 1, 4, 1);
    // R10: order out of range
    cyc("R10", 0, 0, 0, 2, 0, 0, 1);
    cyc("R10", 0, 0, 0, 2, 1, 11, 1);

    // R2: pointer write beats update in the same cycle
    cyc("R2", 1, 0, 16'h0444, 0, 0, 0, 1);
    cyc("R2", 0, 0, 0, 0, 0, 0, 0);
    chk("R2 ptr", last_addr, 16'h0444);
    // R2: step write with update uses old step
    cyc("R2", 1, 1, 7, 0, 0, 0, 1);
    cyc("R2", 0, 0, 0, 0, 1, 0, 1);

    // random blocks
    for (int b = 0; b < 40; b++) begin
      int bs, ln, st, md, lg;
      bs = int'($urandom_range(0, 65535));
      ln = int'($urandom_range(1, 200));
      st = int'($urandom_range(0, ln + 1));
      if ($urandom_range(0, 1) == 1) st = -st;
      md = int'($urandom_range(0, 3));
      lg = int'($urandom_range(0, 11));
      wr(2, bs); wr(3, ln); wr(1, st & 16'hFFFF);
      wr(0, (bs + int'($urandom_range(0, ln - 1))) & 16'hFFFF);
      for (int i = 0; i < 20; i++)
        cyc("R6", 0, 0, 0, md, bit'($urandom_range(0, 1)), lg, bit'($urandom_range(0, 3) != 0));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule